// File: doc/BRIEF.md
# IN Endpoint Write Command Framer

This block sits between a byte-wide microcontroller write channel and the IN side of a low-speed USB device. Every transfer from the microcontroller opens with a header byte. The header holds a toggle flag, a 3-bit internal destination and a 4-bit payload length. When the destination is an IN endpoint FIFO, the framer forwards exactly the announced number of payload bytes to that FIFO's push interface. It records the toggle, which later selects between a DATA0 and a DATA1 PID. Once the packet is complete, it marks the endpoint as armed. When the destination is a device register, a single data byte follows and is issued as a register write.

An armed endpoint refuses further writes until the USB side reports an ACK for it, or until the SETUP logic flushes all IN endpoints. A zero-length header arms the endpoint at once, with no payload. Oversized lengths are clamped and flagged. A write aimed at a blocked endpoint is consumed byte for byte without effect, so the parser stays aligned on header boundaries.

Top module: `in_write_framer`

## Requirements
- R1: A header byte splits into bit 7 = toggle, bits 6:4 = destination, bits 3:0 = length. Destinations 0 to N_EP-1 (default 3) select the IN FIFO of the same number, and higher destinations select registers. After reset and after every complete transfer, the next accepted byte is parsed as a header.
- R2: For an unblocked FIFO destination with length L, the next L accepted bytes each produce a one-cycle push_o with push_ep_o equal to the destination and push_data_o equal to the byte. These outputs appear in the cycle after the byte is accepted. The header byte itself never pushes.
- R3: An accepted FIFO header sets toggle_o of that endpoint to header bit 7 (1 = DATA1, 0 = DATA0), visible the cycle after the header.
- R4: A length above 8 is treated as 8 and raises cnt_err_o for one cycle after the header. The byte following the 8th payload byte is a header.
- R5: armed_o of an endpoint rises together with the push of the final payload byte and stays high while neither ack nor flush arrives.
- R6: A length of 0 to an unblocked FIFO produces no push and sets armed_o of that endpoint in the cycle after the header.
- R7: A header aimed at an armed endpoint raises busy_err_o for one cycle. Its (clamped) payload bytes are consumed with no push, and the endpoint's toggle and armed state are unchanged.
- R8: A register-destination header is followed by exactly one data byte. That byte produces a one-cycle reg_we_o with reg_addr_o = destination and reg_data_o = the byte.
- R9: ack_i[e] clears armed_o[e], and flush_i clears every armed_o bit, one cycle later. An arm event in the same cycle as a clear takes priority, so the endpoint ends up armed.
- R10: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_valid_i | input | 1 | Byte present on byte_i this cycle |
| byte_i | input | 8 | Byte from the microcontroller |
| ack_i | input | N_EP | Per-endpoint ACK from the USB side |
| flush_i | input | 1 | Clear all IN endpoint armed states |
| push_o | output | 1 | FIFO push strobe |
| push_ep_o | output | EPW | Endpoint being pushed |
| push_data_o | output | 8 | Byte being pushed |
| reg_we_o | output | 1 | Register write strobe |
| reg_addr_o | output | 3 | Register destination |
| reg_data_o | output | 8 | Register write data |
| cnt_err_o | output | 1 | Length above 8 was clamped |
| busy_err_o | output | 1 | Write hit an armed endpoint |
| armed_o | output | N_EP | Endpoint waiting for ACK |
| toggle_o | output | N_EP | Recorded DATA1 selection per endpoint |

## Verification
The hardest situations to reach are a discarded write whose payload must still be swallowed, and an arm event that coincides with an ACK for the same endpoint. For the first, the stimulus arms an endpoint with a zero-length header, aims a two-byte write at it, and then issues a register write to show that the parser is still aligned. For the second, the ACK pulse is driven in the same cycle as the final payload byte, and the test confirms that the endpoint ends up armed. A 15-byte length header, followed by a register write after the 8th byte, covers clamping and resynchronisation.

// File: rtl/wcf_pkg.sv
package wcf_pkg;
  typedef enum logic [1:0] {ST_HDR, ST_FILL, ST_DROP, ST_REG} seq_state_e;

  typedef struct packed {
    logic       tog;
    logic [2:0] dest;
    logic [3:0] len;
  } hdr_t;
endpackage

// File: rtl/wcf_hdr_decode.sv
module wcf_hdr_decode #(
  parameter int N_EP    = 3,
  parameter int MAX_LEN = 8,
  parameter int EPW     = 2
) (
  input  logic [7:0]     byte_i,
  output logic           tog_o,
  output logic           is_fifo_o,
  output logic [EPW-1:0] ep_o,
  output logic [2:0]     dest_o,
  output logic [3:0]     len_o,
  output logic           over_o
);
  import wcf_pkg::*;

  localparam logic [3:0] MAX_L = 4'(MAX_LEN);
  localparam logic [3:0] NEP_W = 4'(N_EP);

  hdr_t hdr;
  assign hdr = hdr_t'(byte_i);

  assign tog_o     = hdr.tog;
  assign dest_o    = hdr.dest;
  assign is_fifo_o = {1'b0, hdr.dest} < NEP_W;
  assign ep_o      = EPW'(hdr.dest);
  assign over_o    = hdr.len > MAX_L;
  assign len_o     = over_o ? MAX_L : hdr.len;
endmodule

// File: rtl/wcf_ep_state.sv
module wcf_ep_state (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic ack_i,
  input  logic flush_i,
  input  logic tog_we_i,
  input  logic tog_i,
  output logic armed_o,
  output logic tog_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_o <= 1'b0;
      tog_o   <= 1'b0;
    end else begin
      // arm beats a coincident clear
      if (arm_i)                armed_o <= 1'b1;
      else if (ack_i || flush_i) armed_o <= 1'b0;
      if (tog_we_i) tog_o <= tog_i;
    end
  end

  assert_ack_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i || flush_i) && !arm_i |=> !armed_o);

  assert_arm_holds_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_o && !ack_i && !flush_i |=> armed_o);

  assert_arm_sets_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |=> armed_o);
endmodule

// File: rtl/wcf_seq.sv
module wcf_seq #(
  parameter int N_EP    = 3,
  parameter int MAX_LEN = 8,
  parameter int EPW     = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            byte_valid_i,
  input  logic [7:0]      byte_i,
  input  logic [N_EP-1:0] armed_i,
  output logic            push_o,
  output logic [EPW-1:0]  push_ep_o,
  output logic [7:0]      push_data_o,
  output logic            reg_we_o,
  output logic [2:0]      reg_addr_o,
  output logic [7:0]      reg_data_o,
  output logic            cnt_err_o,
  output logic            busy_err_o,
  output logic [N_EP-1:0] arm_o,
  output logic [N_EP-1:0] tog_we_o,
  output logic            tog_o
);
  import wcf_pkg::*;

  seq_state_e     state_q;
  logic [3:0]     rem_q;
  logic [EPW-1:0] cur_ep_q;

  logic           d_tog, d_fifo, d_over;
  logic [EPW-1:0] d_ep;
  logic [2:0]     d_dest;
  logic [3:0]     d_len;

  wcf_hdr_decode #(.N_EP(N_EP), .MAX_LEN(MAX_LEN), .EPW(EPW)) u_dec (
    .byte_i   (byte_i),
    .tog_o    (d_tog),
    .is_fifo_o(d_fifo),
    .ep_o     (d_ep),
    .dest_o   (d_dest),
    .len_o    (d_len),
    .over_o   (d_over)
  );

  logic [N_EP-1:0] hdr_mask, cur_mask;
  logic hdr_acc, fifo_free, fill_last;

  assign hdr_mask  = N_EP'(1) << d_ep;
  assign cur_mask  = N_EP'(1) << cur_ep_q;
  assign hdr_acc   = byte_valid_i && (state_q == ST_HDR);
  assign fifo_free = hdr_acc && d_fifo && !(|(armed_i & hdr_mask));
  assign fill_last = byte_valid_i && (state_q == ST_FILL) && (rem_q == 4'd1);

  always_comb begin
    arm_o = '0;
    if (fifo_free && d_len == 4'd0) arm_o = hdr_mask;
    else if (fill_last)             arm_o = cur_mask;
  end

  assign tog_we_o = fifo_free ? hdr_mask : '0;
  assign tog_o    = d_tog;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_HDR;
      rem_q       <= '0;
      cur_ep_q    <= '0;
      push_o      <= 1'b0;
      push_ep_o   <= '0;
      push_data_o <= '0;
      reg_we_o    <= 1'b0;
      reg_addr_o  <= '0;
      reg_data_o  <= '0;
      cnt_err_o   <= 1'b0;
      busy_err_o  <= 1'b0;
    end else begin
      push_o     <= 1'b0;
      reg_we_o   <= 1'b0;
      cnt_err_o  <= 1'b0;
      busy_err_o <= 1'b0;
      if (byte_valid_i) begin
        unique case (state_q)
          ST_HDR: begin
            cnt_err_o <= d_over;
            if (d_fifo) begin
              cur_ep_q <= d_ep;
              rem_q    <= d_len;
              if (!fifo_free) begin
                busy_err_o <= 1'b1;
                if (d_len != 4'd0) state_q <= ST_DROP;
              end else if (d_len != 4'd0) begin
                state_q <= ST_FILL;
              end
            end else begin
              reg_addr_o <= d_dest;
              state_q    <= ST_REG;
            end
          end
          ST_FILL: begin
            push_o      <= 1'b1;
            push_ep_o   <= cur_ep_q;
            push_data_o <= byte_i;
            rem_q       <= rem_q - 4'd1;
            if (rem_q == 4'd1) state_q <= ST_HDR;
          end
          ST_DROP: begin
            rem_q <= rem_q - 4'd1;
            if (rem_q == 4'd1) state_q <= ST_HDR;
          end
          ST_REG: begin
            reg_we_o   <= 1'b1;
            reg_data_o <= byte_i;
            state_q    <= ST_HDR;
          end
          default: state_q <= ST_HDR;
        endcase
      end
    end
  end

  assert_len_bounded_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FILL || state_q == ST_DROP) |-> (rem_q != 4'd0 && rem_q <= 4'(MAX_LEN)));

  assert_reg_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o);

  assert_blocked_no_push_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_err_o |-> !push_o && !reg_we_o);

  assert_push_not_armed_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_i && state_q == ST_FILL |-> !(|(armed_i & cur_mask)));
endmodule

// File: rtl/in_write_framer.sv
module in_write_framer #(
  parameter int N_EP    = 3,
  parameter int MAX_LEN = 8,
  localparam int EPW    = (N_EP > 1) ? $clog2(N_EP) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            byte_valid_i,
  input  logic [7:0]      byte_i,
  input  logic [N_EP-1:0] ack_i,
  input  logic            flush_i,
  output logic            push_o,
  output logic [EPW-1:0]  push_ep_o,
  output logic [7:0]      push_data_o,
  output logic            reg_we_o,
  output logic [2:0]      reg_addr_o,
  output logic [7:0]      reg_data_o,
  output logic            cnt_err_o,
  output logic            busy_err_o,
  output logic [N_EP-1:0] armed_o,
  output logic [N_EP-1:0] toggle_o
);
  logic [N_EP-1:0] arm, tog_we;
  logic            tog_bit;

  wcf_seq #(.N_EP(N_EP), .MAX_LEN(MAX_LEN), .EPW(EPW)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .byte_valid_i(byte_valid_i),
    .byte_i      (byte_i),
    .armed_i     (armed_o),
    .push_o      (push_o),
    .push_ep_o   (push_ep_o),
    .push_data_o (push_data_o),
    .reg_we_o    (reg_we_o),
    .reg_addr_o  (reg_addr_o),
    .reg_data_o  (reg_data_o),
    .cnt_err_o   (cnt_err_o),
    .busy_err_o  (busy_err_o),
    .arm_o       (arm),
    .tog_we_o    (tog_we),
    .tog_o       (tog_bit)
  );

  for (genvar e = 0; e < N_EP; e++) begin : g_ep
    wcf_ep_state u_ep (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .arm_i   (arm[e]),
      .ack_i   (ack_i[e]),
      .flush_i (flush_i),
      .tog_we_i(tog_we[e]),
      .tog_i   (tog_bit),
      .armed_o (armed_o[e]),
      .tog_o   (toggle_o[e])
    );
  end
endmodule

// File: tb/in_write_framer_test.sv
module in_write_framer_test;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       valid = 0;
  logic [7:0] din = 0;
  logic [2:0] ack = 0;
  logic       flush = 0;
  logic       push, reg_we, cnt_err, busy_err;
  logic [1:0] push_ep;
  logic [7:0] push_data, reg_data;
  logic [2:0] reg_addr, armed, toggle;

  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  in_write_framer uut (
    .clk_i(clk), .rst_ni(rst_n), .byte_valid_i(valid), .byte_i(din),
    .ack_i(ack), .flush_i(flush), .push_o(push), .push_ep_o(push_ep),
    .push_data_o(push_data), .reg_we_o(reg_we), .reg_addr_o(reg_addr),
    .reg_data_o(reg_data), .cnt_err_o(cnt_err), .busy_err_o(busy_err),
    .armed_o(armed), .toggle_o(toggle)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one byte over one edge; returns at the following negedge
  task automatic send(logic [7:0] b, logic [2:0] a = 3'b0, logic f = 1'b0);
    @(negedge clk);
    valid = 1; din = b; ack = a; flush = f;
    @(negedge clk);
    valid = 0; ack = 0; flush = 0;
  endtask

  task automatic pulse(logic [2:0] a, logic f);
    @(negedge clk);
    ack = a; flush = f;
    @(negedge clk);
    ack = 0; flush = 0;
  endtask

  task automatic reg_write(string req, logic [2:0] dest, logic [7:0] d);
    send({1'b0, dest, 4'd0});
    chk({req, " hdr no we"}, reg_we, 0);
    send(d);
    chk({req, " reg_we"}, reg_we, 1);
    chk({req, " reg_addr"}, reg_addr, dest);
    chk({req, " reg_data"}, reg_data, d);
  endtask

  task automatic t_reset();
    chk("R10 push", push, 0);
    chk("R10 reg_we", reg_we, 0);
    chk("R10 armed", armed, 0);
    chk("R10 toggle", toggle, 0);
    chk("R10 errs", {cnt_err, busy_err}, 0);
  endtask

  task automatic t_fifo_fill();
    send(8'h93); // tog1 ep1 len3
    chk("R2 header no push", push, 0);
    chk("R3 toggle ep1", toggle[1], 1);
    chk("R5 not yet armed", armed[1], 0);
    for (int i = 0; i < 3; i++) begin
      send(8'hA0 + 8'(i));
      chk("R2 push", push, 1);
      chk("R2 push_ep", push_ep, 1);
      chk("R2 push_data", push_data, 8'hA0 + i);
    end
    chk("R5 armed after last", armed[1], 1);
    reg_write("R1 R8 resync", 3'd5, 8'h5A);
  endtask

  task automatic t_hold_ack();
    repeat (4) @(negedge clk);
    chk("R5 armed held", armed[1], 1);
    pulse(3'b010, 1'b0);
    chk("R9 ack clears", armed[1], 0);
  endtask

  task automatic t_zero_len();
    send(8'h20); // tog0 ep2 len0
    chk("R6 no push", push, 0);
    chk("R6 armed now", armed[2], 1);
    chk("R3 toggle ep2 DATA0", toggle[2], 0);
    reg_write("R6 next header", 3'd7, 8'h11);
  endtask

  task automatic t_blocked();
    send(8'hA2); // tog1 ep2 len2, ep2 armed
    chk("R7 busy_err", busy_err, 1);
    chk("R7 toggle kept", toggle[2], 0);
    for (int i = 0; i < 2; i++) begin
      send(8'hC0 + 8'(i));
      chk("R7 no push", push, 0);
      chk("R7 no reg_we", reg_we, 0);
    end
    chk("R7 still armed", armed[2], 1);
    chk("R7 busy pulse ends", busy_err, 0);
    reg_write("R7 resync", 3'd3, 8'h77);
    pulse(3'b000, 1'b1);
    chk("R9 flush clears", armed, 0);
  endtask

  task automatic t_over_len();
    int pushes = 0;
    send(8'h0F); // tog0 ep0 len15
    chk("R4 cnt_err", cnt_err, 1);
    for (int i = 0; i < 8; i++) begin
      send(8'h10 + 8'(i));
      pushes += int'(push);
    end
    chk("R4 clamped pushes", pushes, 8);
    chk("R4 armed ep0", armed[0], 1);
    reg_write("R4 ninth byte is header", 3'd4, 8'h99);
    chk("R4 err pulse gone", cnt_err, 0);
  endtask

  task automatic t_collide();
    pulse(3'b000, 1'b1);
    chk("R9 flush ep0", armed[0], 0);
    send(8'h81); // tog1 ep0 len1
    send(8'hEE, 3'b001, 1'b1);
    chk("R2 push collide", push, 1);
    chk("R9 arm wins", armed[0], 1);
    chk("R3 toggle ep0 DATA1", toggle[0], 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_fifo_fill();
    t_hold_ack();
    t_zero_len();
    t_blocked();
    t_over_len();
    t_collide();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule